// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces a periodic interrupt event from a 32.768 kHz time base. The time base arrives as a one-cycle enable, `tick_en_i`, in the system clock domain. A 4-bit rate code picks the period. Codes 3 to 15 give 2^(code-1) ticks, so code 3 gives 4 ticks and code 15 gives 16384 ticks. The two lowest non-zero codes do not give fast rates. Instead they alias to slower ones: code 1 behaves as code 8 (128 ticks) and code 2 behaves as code 9 (256 ticks).

A 15-bit counter runs freely from reset and advances on every tick. An event does not come a fixed time after the block is enabled. It comes when the count reaches the next whole multiple of the selected period. On each event the block raises a one-cycle pulse toward the interrupt logic. In the same cycle it drives a set-mask of 0xC0 toward a status flag register, where bit 7 marks an interrupt request and bit 6 marks a periodic source.

A small state machine holds the event state. Its states are:
- `ST_OFF`: events are disabled, either because the rate code is zero or because the enable is low.
- `ST_WAIT`: armed, waiting for a boundary.
- `ST_FIRE`: the one cycle in which the pulse and mask are driven.

Its transitions are:
- Any state goes to `ST_OFF` when the block is inactive.
- Any state goes to `ST_FIRE` when the block is active, a tick arrives and the new count is a multiple of the period.
- In every other case it goes to `ST_WAIT`.

Top module: `periodic_rate_gen`

## Requirements
- R1: A synchronous reset clears the free-running count to zero and forces `pulse_o` low and `flag_set_o` to 0x00 in the cycle that follows.
- R2: While `rate_sel_i` is 0, no pulse is ever produced.
- R3: While `pie_en_i` is 0, no pulse is ever produced.
- R4: For rate codes 3 to 15, pulses fall on counts that are multiples of 2^(code-1) ticks.
- R5: Rate code 1 gives a period of 128 ticks and rate code 2 gives a period of 256 ticks.
- R6: Event timing follows the count since reset. When the block is enabled mid-stream, the first pulse comes at the next multiple of the period, not a full period after enabling.
- R7: A pulse appears in the clock cycle right after the edge that sampled the tick bringing the count to a multiple, and it lasts exactly one cycle.
- R8: `flag_set_o` is 0xC0 (bits 7 and 6 set) in a pulse cycle and 0x00 in every other cycle.
- R9: The count advances only on cycles with `tick_en_i` high. Without ticks, no pulse occurs.
- R10: A change of rate code or enable is applied at the next tick, and that tick is judged against the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_en_i | input | 1 | One-cycle 32.768 kHz time-base enable |
| rate_sel_i | input | 4 | Rate code; 0 turns events off |
| pie_en_i | input | 1 | Periodic event enable |
| pulse_o | output | 1 | One-cycle periodic event pulse |
| flag_set_o | output | 8 | Set-mask toward the status flag register (0xC0 on an event) |

## Verification
The assertions assume that `tick_en_i` is a one-cycle strobe sampled on the clock edge. They also assume that reset is held high from time zero until the first edges have passed. The bench drives every input at the falling edge, so each value is stable when the rising edge samples it. Reset is applied at the start of each scenario.

Ticks come both back to back and with idle gaps between them. The gaps let the bench see whether a pulse wrongly lasts past one cycle. Rate and enable changes are placed between ticks and next to boundaries, so the timing that R6 and R10 call for is exercised.

// File: rtl/prd_rate_pkg.sv
package prd_rate_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIRE = 2'd2
    } prd_state_t;

    localparam logic [7:0] PRD_FLAG_MASK = 8'hC0;
endpackage

// File: rtl/prd_rate_decode.sv
module prd_rate_decode #(
    parameter int RATE_W  = 4,
    parameter int CNT_W   = 15,
    parameter int ALIAS_1 = 8,
    parameter int ALIAS_2 = 9
) (
    input  logic [RATE_W-1:0] rate_code,
    input  logic              enable,
    output logic              active,
    output logic [CNT_W-1:0]  low_mask
);
    logic [RATE_W-1:0] eff_code;

    always_comb begin
        eff_code = rate_code;
        if (rate_code == RATE_W'(1)) eff_code = RATE_W'(ALIAS_1);
        if (rate_code == RATE_W'(2)) eff_code = RATE_W'(ALIAS_2);
    end

    assign active = enable && (rate_code != '0);

    // low (code-1) bits of the count must be zero at an event
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            low_mask[i] = (i < (int'(eff_code) - 1));
        end
    end
endmodule

// File: rtl/prd_free_counter.sv
module prd_free_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);
    assign cnt_next = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_next;
        end
    end

    p_clear_r1: assert property (@(posedge clk) rst |=> (cnt_q == '0));
    p_advance_r9: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
    import prd_rate_pkg::*;
#(
    parameter int RATE_W = 4,
    parameter int CNT_W  = 15,
    parameter int FLAG_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_en_i,
    input  logic [RATE_W-1:0] rate_sel_i,
    input  logic              pie_en_i,
    output logic              pulse_o,
    output logic [FLAG_W-1:0] flag_set_o
);
    logic             active;
    logic [CNT_W-1:0] low_mask;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             on_boundary;
    logic             fire_now;
    prd_state_t       state_q;
    prd_state_t       state_d;

    prd_rate_decode #(
        .RATE_W (RATE_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .rate_code (rate_sel_i),
        .enable    (pie_en_i),
        .active    (active),
        .low_mask  (low_mask)
    );

    prd_free_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk_i),
        .rst      (rst_i),
        .tick     (tick_en_i),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next)
    );

    assign on_boundary = ((cnt_next & low_mask) == '0);
    assign fire_now    = active && tick_en_i && on_boundary;

    always_comb begin
        state_d = ST_OFF;
        unique case (state_q)
            ST_OFF: begin
                if (fire_now)    state_d = ST_FIRE;
                else if (active) state_d = ST_WAIT;
                else             state_d = ST_OFF;
            end
            ST_WAIT: begin
                if (!active)       state_d = ST_OFF;
                else if (fire_now) state_d = ST_FIRE;
                else               state_d = ST_WAIT;
            end
            ST_FIRE: begin
                if (!active)       state_d = ST_OFF;
                else if (fire_now) state_d = ST_FIRE;
                else               state_d = ST_WAIT;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_OFF;
        else       state_q <= state_d;
    end

    always_comb begin
        pulse_o    = (state_q == ST_FIRE);
        flag_set_o = pulse_o ? FLAG_W'(PRD_FLAG_MASK) : '0;
    end

    p_reset_r1: assert property (@(posedge clk_i) rst_i |=> !pulse_o);
    p_code_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> ($past(rate_sel_i) != '0));
    p_enable_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> $past(pie_en_i));
    p_aligned_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> ((cnt_q & $past(low_mask)) == '0));
    p_one_cycle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o);
    p_needs_tick_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> $past(tick_en_i));
endmodule

// File: tb/periodic_rate_gen_tb_top.sv
module periodic_rate_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] code = 4'd0;
    logic       pie = 1'b0;
    logic       pulse_o;
    logic [7:0] flag_set_o;

    int    errors = 0;
    int    checks = 0;
    int    m_cnt  = 0;
    bit    q_pulse[$];
    string q_tag[$];
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    periodic_rate_gen dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .tick_en_i  (tick),
        .rate_sel_i (code),
        .pie_en_i   (pie),
        .pulse_o    (pulse_o),
        .flag_set_o (flag_set_o)
    );

    // driver: sets inputs on the falling edge and pushes the expected result
    task automatic step(input bit r, input bit t, input bit p,
                        input logic [3:0] c, input string tag);
        bit exp_p;
        int eff;
        @(negedge clk);
        rst = r; tick = t; pie = p; code = c;
        exp_p = 1'b0;
        if (r) begin
            m_cnt = 0;
        end else if (t) begin
            m_cnt = (m_cnt + 1) % 32768;
            eff = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
            if (p && c != 4'd0)
                exp_p = ((m_cnt % (1 << (eff - 1))) == 0);
        end
        q_pulse.push_back(exp_p);
        q_tag.push_back(tag);
    endtask

    task automatic run(input int n, input int gap, input bit p,
                       input logic [3:0] c, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b1, p, c, tag);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0, p, c, tag);
        end
    endtask

    task automatic do_reset(input string tag);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 4'd0, tag);
    endtask

    // monitor: compares outputs just after each rising edge
    initial begin
        forever begin
            bit    e;
            string t;
            @(posedge clk);
            #1;
            if (q_pulse.size() > 0) begin
                e = q_pulse.pop_front();
                t = q_tag.pop_front();
                checks++;
                if (pulse_o !== e || flag_set_o !== (e ? 8'hC0 : 8'h00)) begin
                    errors++;
                    $display("FAIL %s: pulse=%0b flag=%02h expected pulse=%0b flag=%02h",
                             t, pulse_o, flag_set_o, e, e ? 8'hC0 : 8'h00);
                end
            end
        end
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        run(20, 0, 1'b1, 4'd3, "R4 code 3 back to back");
        run(20, 2, 1'b1, 4'd3, "R7 R8 single cycle pulse and mask");
        run(40, 0, 1'b1, 4'd0, "R2 code zero silent");
        run(40, 1, 1'b0, 4'd6, "R3 enable low silent");
        for (int i = 0; i < 50; i++) step(1'b0, 1'b0, 1'b1, 4'd3, "R9 no tick no event");
        do_reset("R1 reset before alias test");
        run(300, 1, 1'b1, 4'd1, "R5 code 1 is 128 ticks");
        do_reset("R1 reset before alias test");
        run(600, 0, 1'b1, 4'd2, "R5 code 2 is 256 ticks");
        do_reset("R1 reset before align test");
        run(5, 0, 1'b0, 4'd5, "R6 disabled lead in");
        run(30, 1, 1'b1, 4'd5, "R6 first event at next multiple");
        do_reset("R1 reset before rate change");
        run(6, 0, 1'b1, 4'd3, "R10 before change");
        run(12, 1, 1'b1, 4'd4, "R10 after change to code 4");
        run(3, 0, 1'b0, 4'd4, "R10 disable at tick");
        run(20, 0, 1'b1, 4'd5, "R10 re-enable at code 5");
        run(8, 0, 1'b1, 4'd7, "R4 code 7");
        run(17000, 0, 1'b1, 4'd15, "R4 code 15 is 16384 ticks");
        do_reset("R1 final reset");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule